// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block turns single-cycle requests into command-pin activity for a DDR SDRAM device. It drives clock enable, chip select, the three strobe pins, the bank select and the address bus. It does not handle the data path. After reset it runs a power-up phase on its own. First it holds clock enable low for a set number of cycles. It then raises clock enable and sends NOPs for 400 ns. Only after that does it accept any request.

Each timing constraint is given in picoseconds. At elaboration the block rounds each one up to whole clock cycles. Per-bank and global down-counters then hold `req_ready` low until the requested command may legally be issued. Some requests can never be legal in the current bank state, for example a read of a closed bank. Such a request is taken, one error pulse is raised and no command is issued.

The block keeps shadow copies of the base and extended mode registers. From the base register it decodes burst length, burst order and CAS latency. Half the decoded burst length is used in the write-recovery and auto-precharge spacing. Whenever nothing is being issued, the pins carry NOP, or deselect while in a low-power state.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset release, `ddr_cke` stays low for `PU_CKE_CYC` cycles while the pins carry NOP. It is high from clock edge `PU_CKE_CYC`. `init_done` and the first possible `req_ready` come `ceil(400 ns / tCK)` edges later. `req_ready` stays low until then.
- R2: Pin encodings as {cs_n, ras_n, cas_n, we_n} are: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, load-mode 0000, burst-stop 0110. Commands without an address (refresh, burst-stop, NOP) drive bank 0 and address 0. Request opcodes are: 0 load-mode, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 burst-stop, 7 self-refresh, 8 power-down, 9 wake.
- R3: For read and write, column bits 9..0 go to address bits 9..0. Column bits from 10 upward go to address bits from 11 upward. Address bit 10 carries `req_ap`, the auto-precharge flag.
- R4: Precharge with `req_ap`=1 drives address bit 10 high and bank 0, and closes every bank. Otherwise it drives address 0 and the requested bank, and closes only that bank.
- R5: Load-mode puts `req_addr` on the address pins and `req_bank` on the bank pins. Bank 0 updates the base register. From it, burst length = 1 << bits[2:0], burst order = bit 3 and CAS latency = bits[6:4]. Bank 1 updates only `ext_mode`, and the decoded outputs do not change.
- R6: Read or write to a bank waits tRCD after its activate. An activate waits tRRD after any previous activate.
- R7: Precharge of a bank waits tRAS after its activate. An activate of a bank waits tRP after its precharge and tRC after its previous activate, each rounded up (55 ns at 8 ns gives 7 cycles).
- R8: Precharge after a write waits BL/2 + tWR + 1 cycles. Read or write with auto-precharge closes the bank, and the next activate of that bank waits BL/2 + tWR + tRP + 1 cycles.
- R9: Any command waits tMRD after a load-mode and tRFC after a refresh. Refresh, self-refresh and load-mode are rejected while any bank is open.
- R10: A rejected request gives a one-cycle `err` pulse and puts no command on the pins. Rejected requests are: read or write to a closed bank, activate to an open bank, and, in a low-power state, anything except wake.
- R11: Self-refresh issues the refresh encoding with `ddr_cke` low. Clock enable then stays low, with deselect on the pins, until a wake request. After a wake from self-refresh the next command waits tRFC.
- R12: Power-down drives `ddr_cke` low with `ddr_cs_n` high. Wake raises `ddr_cke` with NOP, and the next command may follow at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this edge (issued or rejected) |
| req_op | input | 4 | Request opcode (see R2) |
| req_bank | input | BA_W | Bank select |
| req_addr | input | ADDR_W | Row for activate, register value for load-mode |
| req_col | input | COL_W | Column for read/write |
| req_ap | input | 1 | Auto-precharge (read/write) or all-banks (precharge) |
| err | output | 1 | One-cycle pulse on a rejected request |
| init_done | output | 1 | Power-up phase finished |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_a | output | ADDR_W | Address bus |
| burst_len | output | 8 | Decoded burst length |
| burst_order | output | 1 | Decoded burst order |
| cas_lat | output | 3 | Decoded CAS latency |
| ext_mode | output | ADDR_W | Shadow extended mode register |

## Verification
The assertions assume `req_op`, `req_bank`, `req_col` and `req_ap` stay stable while `req_valid` is high and `req_ready` is low. They also assume the timing parameters are at least one cycle and small enough for the counter width. The bench keeps to this: it changes request fields only on falling edges, holds a request until it has been taken, and drops `req_valid` right after the accepting edge. Each request is placed at the earliest cycle it could be legal, so a measured gap shows both a stall that is too short and one that is too long.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

  typedef enum logic [3:0] {
    OP_LMR  = 4'd0, OP_ACT  = 4'd1, OP_RD   = 4'd2, OP_WR   = 4'd3,
    OP_PRE  = 4'd4, OP_REF  = 4'd5, OP_BST  = 4'd6, OP_SREF = 4'd7,
    OP_PDN  = 4'd8, OP_WAKE = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_PWR_LOW, ST_PWR_NOP, ST_RUN, ST_SELF, ST_DOWN
  } st_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP   = 4'b0111;
  localparam logic [3:0] PIN_ACT   = 4'b0011;
  localparam logic [3:0] PIN_RD    = 4'b0101;
  localparam logic [3:0] PIN_WR    = 4'b0100;
  localparam logic [3:0] PIN_PRE   = 4'b0010;
  localparam logic [3:0] PIN_REF   = 4'b0001;
  localparam logic [3:0] PIN_LMR   = 4'b0000;
  localparam logic [3:0] PIN_BST   = 4'b0110;
  localparam logic [3:0] PIN_DESEL = 4'b1111;

  // Round a picosecond span up to whole clocks, never below one.
  function automatic int ps2cyc(int t_ps, int tck_ps);
    int c;
    c = (t_ps + tck_ps - 1) / tck_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ddrseq_cnt.sv
module ddrseq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] gap,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d, dec;

  // A load never shortens a wait already running.
  always_comb begin
    dec   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    cnt_d = dec;
    if (load && (gap != '0) && ((gap - 1'b1) > dec)) cnt_d = gap - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && gap > 1) |=> !zero);
endmodule

// File: rtl/ddrseq_bank.sv
module ddrseq_bank #(
  parameter int W    = 8,
  parameter int TRC  = 7,
  parameter int TRP  = 2,
  parameter int TRAS = 5,
  parameter int TRCD = 2,
  parameter int TWR  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_go,
  input  logic         rw_go,
  input  logic         wr,
  input  logic         ap,
  input  logic         pre_go,
  input  logic [W-1:0] bl_half,
  output logic         is_open,
  output logic         act_ok,
  output logic         rw_ok,
  output logic         pre_ok
);
  logic         open_d;
  logic         act_ld, pre_ld;
  logic [W-1:0] act_gap, pre_gap;
  logic         act_z, pre_z, rcd_z;

  always_comb begin
    open_d  = is_open;
    act_ld  = act_go | pre_go | (rw_go & ap);
    act_gap = W'(TRC);
    pre_ld  = act_go | (rw_go & wr & ~ap);
    pre_gap = W'(TRAS);
    if (act_go) open_d = 1'b1;
    if (pre_go) begin
      open_d  = 1'b0;
      act_gap = W'(TRP);
    end
    if (rw_go && ap) begin
      open_d  = 1'b0;
      act_gap = bl_half + W'(TWR + TRP + 1);
    end
    if (rw_go && wr && !ap) pre_gap = bl_half + W'(TWR + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) is_open <= 1'b0;
    else        is_open <= open_d;
  end

  ddrseq_cnt #(.W(W)) u_act (.clk(clk), .rst_n(rst_n), .load(act_ld),
                             .gap(act_gap), .zero(act_z));
  ddrseq_cnt #(.W(W)) u_pre (.clk(clk), .rst_n(rst_n), .load(pre_ld),
                             .gap(pre_gap), .zero(pre_z));
  ddrseq_cnt #(.W(W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_go),
                             .gap(W'(TRCD)), .zero(rcd_z));

  assign act_ok = !is_open && act_z;
  assign rw_ok  = is_open && rcd_z;
  assign pre_ok = pre_z;

  p_rw_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rw_go |-> is_open);
  p_act_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> !is_open);
  p_rcd_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (TRCD > 1 && act_go) |=> !rw_ok);
endmodule

// File: rtl/ddrseq_mode.sv
module ddrseq_mode #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lmr_go,
  input  logic [BA_W-1:0]   sel,
  input  logic [ADDR_W-1:0] val,
  output logic [7:0]        bl,
  output logic              bo,
  output logic [2:0]        cl,
  output logic [ADDR_W-1:0] ext_q
);
  logic [ADDR_W-1:0] base_q;
  logic              base_en, ext_en;

  assign base_en = lmr_go && (sel == BA_W'(0));
  assign ext_en  = lmr_go && (sel == BA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ext_q  <= '0;
    end else begin
      if (base_en) base_q <= val;
      if (ext_en)  ext_q  <= val;
    end
  end

  assign bl = 8'd1 << base_q[2:0];
  assign bo = base_q[3];
  assign cl = base_q[6:4];

  p_ext_keeps_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |=> $stable(bl) && $stable(cl) && $stable(bo));
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddrseq_pkg::*;
#(
  parameter int TCK_PS     = 8000,
  parameter int T_MRD_PS   = 12000,
  parameter int T_RAS_PS   = 40000,
  parameter int T_RC_PS    = 55000,
  parameter int T_RFC_PS   = 72000,
  parameter int T_RCD_PS   = 15000,
  parameter int T_RP_PS    = 15000,
  parameter int T_RRD_PS   = 10000,
  parameter int T_WR_PS    = 15000,
  parameter int T_INIT_PS  = 400000,
  parameter int PU_CKE_CYC = 10,
  parameter int BA_W       = 2,
  parameter int ADDR_W     = 13,
  parameter int COL_W      = 11,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  output logic              err,
  output logic              init_done,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_a,
  output logic [7:0]        burst_len,
  output logic              burst_order,
  output logic [2:0]        cas_lat,
  output logic [ADDR_W-1:0] ext_mode
);
  localparam int NBANK  = 1 << BA_W;
  localparam int TMRD_C = ps2cyc(T_MRD_PS, TCK_PS);
  localparam int TRAS_C = ps2cyc(T_RAS_PS, TCK_PS);
  localparam int TRC_C  = ps2cyc(T_RC_PS,  TCK_PS);
  localparam int TRFC_C = ps2cyc(T_RFC_PS, TCK_PS);
  localparam int TRCD_C = ps2cyc(T_RCD_PS, TCK_PS);
  localparam int TRP_C  = ps2cyc(T_RP_PS,  TCK_PS);
  localparam int TRRD_C = ps2cyc(T_RRD_PS, TCK_PS);
  localparam int TWR_C  = ps2cyc(T_WR_PS,  TCK_PS);
  localparam int INIT_C = ps2cyc(T_INIT_PS, TCK_PS);
  localparam int PU_MAX = (PU_CKE_CYC > INIT_C) ? PU_CKE_CYC : INIT_C;
  localparam int PW     = $clog2(PU_MAX + 1);

  op_e               op;
  st_e               state_q, state_d;
  logic [PW-1:0]     pu_q, pu_d;
  logic [3:0]        pins_q, pins_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] a_d, col_addr;
  logic              cke_d, err_d, go_ok, bad, take, rej;
  logic              g_zero, rrd_zero, g_load;
  logic [CNT_W-1:0]  g_gap, bl_half;
  logic [NBANK-1:0]  open_v, act_ok_v, rw_ok_v, pre_ok_v;
  logic [NBANK-1:0]  act_go_v, rw_go_v, pre_go_v;
  logic              any_open, low_pwr;

  assign op       = op_e'(req_op);
  assign any_open = |open_v;
  assign low_pwr  = (state_q == ST_SELF) || (state_q == ST_DOWN);
  assign bl_half  = CNT_W'(burst_len[7:1]);

  // Legality of the pending request in the current state.
  always_comb begin
    go_ok = 1'b0;
    bad   = 1'b0;
    if (state_q == ST_RUN) begin
      case (op)
        OP_LMR, OP_REF, OP_SREF:
          if (any_open) bad = 1'b1;
          else          go_ok = g_zero && (&act_ok_v);
        OP_ACT:
          if (open_v[req_bank]) bad = 1'b1;
          else go_ok = g_zero && rrd_zero && act_ok_v[req_bank];
        OP_RD, OP_WR:
          if (!open_v[req_bank]) bad = 1'b1;
          else go_ok = g_zero && rw_ok_v[req_bank];
        OP_PRE:  go_ok = g_zero && (req_ap ? (&pre_ok_v) : pre_ok_v[req_bank]);
        OP_BST, OP_PDN: go_ok = g_zero;
        default: bad = 1'b1;
      endcase
    end else if (low_pwr) begin
      if (op == OP_WAKE) go_ok = 1'b1;
      else               bad   = 1'b1;
    end
  end

  assign req_ready = go_ok | bad;
  assign take      = req_valid & go_ok;
  assign rej       = req_valid & bad;

  // Column split around the auto-precharge bit.
  always_comb begin
    col_addr       = '0;
    col_addr[9:0]  = req_col[9:0];
    col_addr[10]   = req_ap;
    for (int i = 10; i < COL_W; i++) col_addr[i+1] = req_col[i];
  end

  // Next state and pin values.
  always_comb begin
    state_d = state_q;
    pu_d    = pu_q;
    pins_d  = low_pwr ? PIN_DESEL : PIN_NOP;
    ba_d    = '0;
    a_d     = '0;
    err_d   = rej;
    case (state_q)
      ST_PWR_LOW:
        if (pu_q == '0) begin
          state_d = ST_PWR_NOP;
          pu_d    = PW'(INIT_C - 1);
        end else pu_d = pu_q - 1'b1;
      ST_PWR_NOP:
        if (pu_q == '0) state_d = ST_RUN;
        else            pu_d = pu_q - 1'b1;
      default: ;
    endcase
    if (take) begin
      case (op)
        OP_LMR:  begin pins_d = PIN_LMR; ba_d = req_bank; a_d = req_addr; end
        OP_ACT:  begin pins_d = PIN_ACT; ba_d = req_bank; a_d = req_addr; end
        OP_RD:   begin pins_d = PIN_RD;  ba_d = req_bank; a_d = col_addr; end
        OP_WR:   begin pins_d = PIN_WR;  ba_d = req_bank; a_d = col_addr; end
        OP_PRE:  begin
          pins_d = PIN_PRE;
          ba_d   = req_ap ? '0 : req_bank;
          a_d[10] = req_ap;
        end
        OP_REF:  pins_d = PIN_REF;
        OP_BST:  pins_d = PIN_BST;
        OP_SREF: begin pins_d = PIN_REF;   state_d = ST_SELF; end
        OP_PDN:  begin pins_d = PIN_DESEL; state_d = ST_DOWN; end
        OP_WAKE: begin pins_d = PIN_NOP;   state_d = ST_RUN;  end
        default: ;
      endcase
    end
    cke_d = !((state_d == ST_PWR_LOW) || (state_d == ST_SELF) ||
              (state_d == ST_DOWN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR_LOW;
      pu_q    <= PW'(PU_CKE_CYC - 1);
      pins_q  <= PIN_NOP;
      ddr_ba  <= '0;
      ddr_a   <= '0;
      ddr_cke <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      pu_q    <= pu_d;
      pins_q  <= pins_d;
      ddr_ba  <= ba_d;
      ddr_a   <= a_d;
      ddr_cke <= cke_d;
      err     <= err_d;
    end
  end

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = pins_q;
  assign init_done = (state_q != ST_PWR_LOW) && (state_q != ST_PWR_NOP);

  // Global spacing: load-mode, refresh, wake from self-refresh.
  assign g_load = take && ((op == OP_LMR) || (op == OP_REF) ||
                           ((op == OP_WAKE) && (state_q == ST_SELF)));
  assign g_gap  = (op == OP_LMR) ? CNT_W'(TMRD_C) : CNT_W'(TRFC_C);

  ddrseq_cnt #(.W(CNT_W)) u_glob (.clk(clk), .rst_n(rst_n), .load(g_load),
                                  .gap(g_gap), .zero(g_zero));
  ddrseq_cnt #(.W(CNT_W)) u_rrd (.clk(clk), .rst_n(rst_n),
                                 .load(take && (op == OP_ACT)),
                                 .gap(CNT_W'(TRRD_C)), .zero(rrd_zero));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_go_v[b] = take && (op == OP_ACT) && (req_bank == BA_W'(b));
    assign rw_go_v[b]  = take && ((op == OP_RD) || (op == OP_WR)) &&
                         (req_bank == BA_W'(b));
    assign pre_go_v[b] = take && (op == OP_PRE) &&
                         (req_ap || (req_bank == BA_W'(b)));
    ddrseq_bank #(.W(CNT_W), .TRC(TRC_C), .TRP(TRP_C), .TRAS(TRAS_C),
                  .TRCD(TRCD_C), .TWR(TWR_C)) u_bank (
      .clk(clk), .rst_n(rst_n), .act_go(act_go_v[b]), .rw_go(rw_go_v[b]),
      .wr(op == OP_WR), .ap(req_ap), .pre_go(pre_go_v[b]),
      .bl_half(bl_half), .is_open(open_v[b]), .act_ok(act_ok_v[b]),
      .rw_ok(rw_ok_v[b]), .pre_ok(pre_ok_v[b]));
  end

  ddrseq_mode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .lmr_go(take && (op == OP_LMR)),
    .sel(req_bank), .val(req_addr), .bl(burst_len), .bo(burst_order),
    .cl(cas_lat), .ext_q(ext_mode));

  p_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ddr_ras_n && ddr_cas_n && ddr_we_n));
  p_mrd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (TMRD_C > 1 && pins_q == PIN_LMR) |=> (ddr_ras_n && ddr_cas_n && ddr_we_n));
  p_sref_cke_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PIN_REF && !ddr_cke) |=> !ddr_cke);
endmodule

// File: tb/tb_ddr_cmd_seq.sv
module tb_ddr_cmd_seq;
  localparam int TCK = 8000;
  localparam int N_LOW = 10;
  localparam int N_NOP = (400000 + TCK - 1) / TCK;   // 50
  localparam int G_MRD = 2, G_RRD = 2, G_RCD = 2, G_RAS = 5, G_RP = 2;
  localparam int G_RC  = 7, G_RFC = 9, G_WR = 2;

  typedef struct packed {
    logic        cke;
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [12:0] a;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ap = 1'b0;
  logic [3:0] req_op = '0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_addr = '0;
  logic [10:0] req_col = '0;
  logic req_ready, err, init_done, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [1:0] ddr_ba;
  logic [12:0] ddr_a, ext_mode;
  logic [7:0] burst_len;
  logic burst_order;
  logic [2:0] cas_lat;

  int checks = 0, fails = 0, cycle = 0;
  bit done = 0;
  ev_t q[$];

  ddr_cmd_seq dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_bank(req_bank),
    .req_addr(req_addr), .req_col(req_col), .req_ap(req_ap), .err(err),
    .init_done(init_done), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
    .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_a(ddr_a), .burst_len(burst_len),
    .burst_order(burst_order), .cas_lat(cas_lat), .ext_mode(ext_mode));

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic ev_t mk(logic c, logic [3:0] p, logic [1:0] b, logic [12:0] a);
    ev_t e;
    e.cke = c; e.pins = p; e.ba = b; e.a = a;
    return e;
  endfunction

  // Monitor: every visible command is popped against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !ddr_cs_n && {ddr_ras_n, ddr_cas_n, ddr_we_n} != 3'b111) begin
      ev_t got, exp;
      got = mk(ddr_cke, {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, ddr_ba, ddr_a);
      if (q.size() == 0) chk(0, "R10", "unexpected command", got, 0);
      else begin
        exp = q.pop_front();
        chk(got == exp, "R2", "command pins", got, exp);
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] bk,
                       input logic [12:0] ad, input logic [10:0] col,
                       input logic ap, input bit push, input ev_t exp,
                       output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bk; req_addr = ad;
    req_col = col; req_ap = ap;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    cyc = cycle;
    if (push) q.push_back(exp);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic reject(input logic [3:0] op, input logic [1:0] bk,
                        input logic ap, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bk; req_col = '0; req_ap = ap;
    #1;
    chk(req_ready == 1'b1, rq, "reject taken at once", req_ready, 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(err == 1'b1, rq, "err pulse", err, 1);
    @(posedge clk); #1;
    chk(err == 1'b0, rq, "err one cycle", err, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int k_cke, k_init, c0, c1, ca0, ca1, cr, cp, cg, cw, cw0, cx, cref, cwk;
    bit pins_ok, rdy_ok;
    ev_t z;
    z = '0;
    k_cke = -1; k_init = -1; pins_ok = 1; rdy_ok = 1;
    repeat (3) @(negedge clk);
    chk(ddr_cke == 0 && err == 0 && init_done == 0, "R1", "reset state",
        {ddr_cke, err, init_done}, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= N_LOW + N_NOP + 2; k++) begin
      @(posedge clk); #1;
      if (ddr_cke && k_cke < 0) k_cke = k;
      if (init_done && k_init < 0) k_init = k;
      if (!init_done && req_ready) rdy_ok = 0;
      if ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} != 4'b0111) pins_ok = 0;
    end
    chk(k_cke == N_LOW, "R1", "cke rise edge", k_cke, N_LOW);
    chk(k_init == N_LOW + N_NOP, "R1", "init_done edge", k_init, N_LOW + N_NOP);
    chk(rdy_ok, "R1", "ready low during power-up", rdy_ok, 1);
    chk(pins_ok, "R1", "NOP pins during power-up", pins_ok, 1);

    // R5: extended register first, decode must stay at reset value
    issue(4'd0, 2'd1, 13'h005, '0, 0, 1, mk(1, 4'b0000, 2'd1, 13'h005), c0);
    chk(ext_mode == 13'h005, "R5", "ext_mode", ext_mode, 13'h005);
    chk(burst_len == 8'd1, "R5", "bl unchanged by ext", burst_len, 1);
    issue(4'd0, 2'd0, 13'h032, '0, 0, 1, mk(1, 4'b0000, 2'd0, 13'h032), c1);
    chk(c1 - c0 == G_MRD, "R9", "tMRD gap", c1 - c0, G_MRD);
    chk(burst_len == 8'd4 && cas_lat == 3'd3 && burst_order == 0, "R5",
        "mode decode", {burst_len, cas_lat, burst_order}, {8'd4, 3'd3, 1'b0});

    issue(4'd1, 2'd0, 13'h1ABC, '0, 0, 1, mk(1, 4'b0011, 2'd0, 13'h1ABC), ca0);
    chk(ca0 - c1 == G_MRD, "R9", "tMRD to activate", ca0 - c1, G_MRD);
    issue(4'd1, 2'd1, 13'h0123, '0, 0, 1, mk(1, 4'b0011, 2'd1, 13'h0123), ca1);
    chk(ca1 - ca0 == G_RRD, "R6", "tRRD", ca1 - ca0, G_RRD);
    // R3: column 0x5A5 -> a = 0x1A5 | bit11
    issue(4'd2, 2'd1, '0, 11'h5A5, 0, 1, mk(1, 4'b0101, 2'd1, 13'h09A5), cr);
    chk(cr - ca1 == G_RCD, "R6", "tRCD", cr - ca1, G_RCD);
    issue(4'd4, 2'd0, '0, '0, 0, 1, mk(1, 4'b0010, 2'd0, 13'h0), cp);
    chk(cp - ca0 == G_RAS, "R7", "tRAS", cp - ca0, G_RAS);
    issue(4'd1, 2'd0, 13'h0042, '0, 0, 1, mk(1, 4'b0011, 2'd0, 13'h0042), cg);
    chk(cg - cp == G_RP, "R7", "tRP", cg - cp, G_RP);
    chk(cg - ca0 == G_RC, "R7", "tRC", cg - ca0, G_RC);

    reject(4'd2, 2'd2, 0, "R10");           // read closed bank
    reject(4'd1, 2'd1, 0, "R10");           // activate open bank

    // R3/R8: write with auto-precharge, bank 1
    issue(4'd3, 2'd1, '0, 11'h00F, 1, 1, mk(1, 4'b0100, 2'd1, 13'h040F), cw);
    reject(4'd2, 2'd1, 0, "R8");            // bank now closed
    issue(4'd1, 2'd1, 13'h0777, '0, 0, 1, mk(1, 4'b0011, 2'd1, 13'h0777), cx);
    chk(cx - cw == 4 / 2 + G_WR + G_RP + 1, "R8", "auto-precharge gap",
        cx - cw, 4 / 2 + G_WR + G_RP + 1);

    issue(4'd3, 2'd0, '0, 11'h010, 0, 1, mk(1, 4'b0100, 2'd0, 13'h0010), cw0);
    issue(4'd4, 2'd0, '0, '0, 0, 1, mk(1, 4'b0010, 2'd0, 13'h0), cp);
    chk(cp - cw0 == 4 / 2 + G_WR + 1, "R8", "write recovery", cp - cw0,
        4 / 2 + G_WR + 1);

    reject(4'd5, 2'd0, 0, "R9");            // refresh with bank 1 open
    issue(4'd4, 2'd3, '0, '0, 1, 1, mk(1, 4'b0010, 2'd0, 13'h0400), cp);
    reject(4'd2, 2'd1, 0, "R4");            // precharge-all closed bank 1
    issue(4'd5, 2'd0, '0, '0, 0, 1, mk(1, 4'b0001, 2'd0, 13'h0), cref);
    issue(4'd1, 2'd2, 13'h0055, '0, 0, 1, mk(1, 4'b0011, 2'd2, 13'h0055), cx);
    chk(cx - cref == G_RFC, "R9", "tRFC", cx - cref, G_RFC);
    issue(4'd6, 2'd0, '0, '0, 0, 1, mk(1, 4'b0110, 2'd0, 13'h0), cx);

    // R5: new mode value after closing all banks
    reject(4'd0, 2'd0, 0, "R9");            // load-mode with bank 2 open
    issue(4'd4, 2'd0, '0, '0, 1, 1, mk(1, 4'b0010, 2'd0, 13'h0400), cp);
    issue(4'd0, 2'd0, 13'h02B, '0, 0, 1, mk(1, 4'b0000, 2'd0, 13'h02B), cx);
    chk(burst_len == 8'd8 && cas_lat == 3'd2 && burst_order == 1, "R5",
        "mode decode 2", {burst_len, cas_lat, burst_order}, {8'd8, 3'd2, 1'b1});

    // R11: self-refresh
    issue(4'd7, 2'd0, '0, '0, 0, 1, mk(0, 4'b0001, 2'd0, 13'h0), cx);
    chk(ddr_cke == 0, "R11", "cke low on entry", ddr_cke, 0);
    repeat (3) @(negedge clk);
    chk(ddr_cke == 0 && ddr_cs_n == 1, "R11", "held in self-refresh",
        {ddr_cke, ddr_cs_n}, 2'b01);
    reject(4'd1, 2'd0, 0, "R10");
    issue(4'd9, 2'd0, '0, '0, 0, 0, z, cwk);
    chk(ddr_cke == 1, "R11", "cke high after wake", ddr_cke, 1);
    issue(4'd1, 2'd3, 13'h0011, '0, 0, 1, mk(1, 4'b0011, 2'd3, 13'h0011), cx);
    chk(cx - cwk == G_RFC, "R11", "exit spacing", cx - cwk, G_RFC);

    // R12: power-down with bank 3 open
    issue(4'd8, 2'd0, '0, '0, 0, 0, z, cx);
    chk(ddr_cke == 0 && ddr_cs_n == 1, "R12", "power-down pins",
        {ddr_cke, ddr_cs_n}, 2'b01);
    issue(4'd9, 2'd0, '0, '0, 0, 0, z, cwk);
    chk(ddr_cke == 1 && {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111,
        "R12", "wake NOP", {ddr_cke, ddr_cs_n, ddr_ras_n}, 3'b101);
    issue(4'd2, 2'd3, '0, 11'h001, 0, 1, mk(1, 4'b0101, 2'd3, 13'h0001), cx);
    chk(cx - cwk == 1, "R12", "command right after wake", cx - cwk, 1);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule